// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel hung off a free-running time counter. Software programs a control/status register and a compare value. The channel watches the counter. When the count equals the armed compare value, it latches a sticky event flag and can raise an interrupt. It also drives an output pin, either toggling it or pulsing it high for one cycle.

The compare value is held in two stages. While one value is armed, software can queue the next one, and the queued value takes over the cycle after the match. Periodic waveforms such as a pulse-per-second train come from rewriting the compare register on every event. Each such write is one period ahead of the value that is now armed.

A wrap-permit input controls what happens when the counter rolls over. If it is low, a counter wrap cancels any armed compare.

Top module: `tcc_compare_chan`

## Requirements
- R1: After reset `ctrl_o`, `cmp_o`, `pin_o` and `irq_o` are all zero.
- R2: Control register layout: bit 0 is the DMA-request enable, bits 5:2 are the mode, bit 6 is the interrupt enable and bit 7 is the event flag. Bits 0 and 2 to 6 read back as written. Bit 1 always reads 0.
- R3: A match happens when the count equals the armed active compare value and the mode is 0x5 or 0xF. A match sets the flag at the next clock edge. Writing 1 to bit 7 clears the flag, and writing 0 to bit 7 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag stays set.
- R4: `irq_o` is high exactly when both the flag and the interrupt enable are set.
- R5: In mode 0x5 the pin inverts at the clock edge that ends the match cycle.
- R6: In mode 0xF the pin is high for exactly the one cycle after each match and low otherwise.
- R7: While the mode is 0, a compare write (wr_sel_i=1) loads the active stage directly and arms it, but no match can occur.
- R8: With a nonzero mode and the active stage armed, a compare write goes to the pending stage, and a second such write overwrites it. On a match the pending value becomes active for the next cycle. A compare write in the match cycle itself is queued behind the pending value if one exists; otherwise it becomes the new armed value.
- R9: After a match with nothing pending, the channel is idle and produces no further match until the next compare write.
- R10: A control write that changes the mode from nonzero to 0 disarms both stages and drives the pin low.
- R11: When wrap_i is high and wrap_en_i is low, both stages are disarmed and no match occurs in that cycle. This drop takes priority over a coincident compare write. When wrap_en_i is high, wrap_i has no effect.
- R12: A compare write keeps only the low CNT_W bits of the data. `cmp_o` shows the active stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CNT_W | Wrapped time counter value |
| wrap_i | input | 1 | Counter period wrap happens this cycle |
| wrap_en_i | input | 1 | Permit compares across a counter wrap |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = compare register |
| wr_data_i | input | DATA_W | Write data |
| ctrl_o | output | 8 | Control/status register readback |
| cmp_o | output | CNT_W | Active compare value |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Compare output pin |

## Verification
On every cycle the assertions check these properties: a match sets the flag, and the flag holds until a 1 is written to bit 7. The pin inverts on each toggle-mode match, and a pulse-mode high lasts a single cycle. No match can occur while the mode is 0 or the active stage is idle. Only the bench scenarios can show that the expected compare value fires at the right count. They also cover the ordering of the pending stage against the active one, the loss of queued values on disable or on an unpermitted wrap, and how a match interacts with a write in the same cycle.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned CTRL_W = 8;
  localparam logic [3:0] MODE_OFF    = 4'h0;
  localparam logic [3:0] MODE_TOGGLE = 4'h5;
  localparam logic [3:0] MODE_PULSE  = 4'hF;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic [3:0] mode;
    logic       rsvd;
    logic       dma_en;
  } ctrl_t;
endpackage

// File: rtl/tcc_ctrl_reg.sv
module tcc_ctrl_reg
  import tcc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              hit_i,
  output ctrl_t             ctrl_o,
  output logic              dis_o
);
  ctrl_t q;
  ctrl_t wd;

  assign wd    = ctrl_t'(wdata_i);
  assign dis_o = wr_i && (q.mode != MODE_OFF) && (wd.mode == MODE_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      if (wr_i) begin
        q.dma_en <= wd.dma_en;
        q.mode   <= wd.mode;
        q.ie     <= wd.ie;
      end
      // set beats write-1-to-clear
      if (hit_i)                 q.flag <= 1'b1;
      else if (wr_i && wd.flag)  q.flag <= 1'b0;
    end
  end

  assign ctrl_o = '{flag: q.flag, ie: q.ie, mode: q.mode, rsvd: 1'b0, dma_en: q.dma_en};
endmodule

// File: rtl/tcc_cmp_buf.sv
module tcc_cmp_buf #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             mode_on_i,
  input  logic             match_en_i,
  input  logic             drop_i,
  output logic             hit_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] act_q, pend_q;
  logic             act_vld_q, pend_vld_q;

  assign hit_o   = act_vld_q && match_en_i && !drop_i && (cnt_i == act_q);
  assign armed_o = act_vld_q;
  assign act_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '0;
      pend_q     <= '0;
      act_vld_q  <= 1'b0;
      pend_vld_q <= 1'b0;
    end else if (drop_i) begin
      act_vld_q  <= 1'b0;
      pend_vld_q <= 1'b0;
    end else if (hit_o) begin
      if (wr_i) begin
        if (pend_vld_q) begin
          act_q  <= pend_q;
          pend_q <= wdata_i;
        end else begin
          act_q <= wdata_i;
        end
      end else if (pend_vld_q) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end else begin
        act_vld_q <= 1'b0;
      end
    end else if (wr_i) begin
      if (mode_on_i && act_vld_q) begin
        pend_q     <= wdata_i;
        pend_vld_q <= 1'b1;
      end else begin
        act_q     <= wdata_i;
        act_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcc_pin_drv.sv
module tcc_pin_drv
  import tcc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  input  logic       hit_i,
  input  logic       clr_i,
  output logic       pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pin_q <= 1'b0;
    else if (clr_i)                 pin_q <= 1'b0;
    else if (mode_i == MODE_TOGGLE) pin_q <= pin_q ^ hit_i;
    else if (mode_i == MODE_PULSE)  pin_q <= hit_i;
    else if (mode_i == MODE_OFF)    pin_q <= 1'b0;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/tcc_compare_chan.sv
module tcc_compare_chan
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wrap_i,
  input  logic              wrap_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              irq_o,
  output logic              pin_o
);
  ctrl_t ctrl;
  logic  hit, armed, dis, drop, wr_ctrl, wr_cmp, mode_on, match_en;

  assign wr_ctrl  = wr_en_i && !wr_sel_i;
  assign wr_cmp   = wr_en_i &&  wr_sel_i;
  assign mode_on  = ctrl.mode != MODE_OFF;
  assign match_en = (ctrl.mode == MODE_TOGGLE) || (ctrl.mode == MODE_PULSE);
  assign drop     = dis || (wrap_i && !wrap_en_i);

  tcc_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ctrl),
    .wdata_i (wr_data_i[CTRL_W-1:0]),
    .hit_i   (hit),
    .ctrl_o  (ctrl),
    .dis_o   (dis)
  );

  tcc_cmp_buf #(.CNT_W(CNT_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (count_i),
    .wr_i       (wr_cmp),
    .wdata_i    (wr_data_i[CNT_W-1:0]),
    .mode_on_i  (mode_on),
    .match_en_i (match_en),
    .drop_i     (drop),
    .hit_o      (hit),
    .armed_o    (armed),
    .act_o      (cmp_o)
  );

  tcc_pin_drv u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (ctrl.mode),
    .hit_i  (hit),
    .clr_i  (dis),
    .pin_o  (pin_o)
  );

  assign ctrl_o = ctrl;
  assign irq_o  = ctrl.flag && ctrl.ie;
endmodule

// File: rtl/tcc_compare_chan_chk.sv
module tcc_compare_chan_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [7:0]        ctrl_o,
  input logic              irq_o,
  input logic              pin_o,
  input logic              hit,
  input logic              armed
);
  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && !wr_sel_i;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> ctrl_o[7]); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] && !(wr_ctrl && wr_data_i[7])) |=> ctrl_o[7]); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl_o[7] && ctrl_o[6])); // R4
  AST_TOGGLE_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[5:2] == 4'h5 && hit && !wr_ctrl) |=> (pin_o != $past(pin_o))); // R5
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[5:2] == 4'hF && pin_o && !hit) |=> !pin_o); // R6
  AST_NO_HIT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[5:2] == 4'h0) |-> !hit); // R7
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !hit); // R9
endmodule

bind tcc_compare_chan tcc_compare_chan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .ctrl_o    (ctrl_o),
  .irq_o     (irq_o),
  .pin_o     (pin_o),
  .hit       (hit),
  .armed     (armed)
);

// File: tb/tcc_compare_chan_bench.sv
module tcc_compare_chan_bench;
  localparam int CW = 8;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          wrap_i = 1'b0;
  logic          wrap_en_i = 1'b1;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [7:0]    ctrl_o;
  logic [CW-1:0] cmp_o;
  logic          irq_o, pin_o;

  int n_chk = 0, n_err = 0;
  bit exp_pin = 0, exp_flag = 0;

  always #10 clk_i = ~clk_i;

  tcc_compare_chan #(.CNT_W(CW), .DATA_W(DW)) u_tcc_compare_chan (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_i), .wrap_i(wrap_i),
    .wrap_en_i(wrap_en_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .ctrl_o(ctrl_o), .cmp_o(cmp_o),
    .irq_o(irq_o), .pin_o(pin_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int c, input bit we, input bit sel, input logic [DW-1:0] d, input bit wr);
    count_i   = CW'(c);
    wr_en_i   = we;
    wr_sel_i  = sel;
    wr_data_i = d;
    wrap_i    = wr;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wrap_i  = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [DW-1:0] d, input int c);
    cyc(c, 1, 0, d, 0);
  endtask

  task automatic wr_cmp(input logic [DW-1:0] d, input int c);
    cyc(c, 1, 1, d, 0);
  endtask

  // expects match at h1, then at h2; index i maps to count i%256, wrap on rollover
  task automatic sweep(input int from, input int to, input int h1, input int h2, input bit pulse, input string req);
    int stage = 0;
    for (int i = from; i <= to; i++) begin
      int c = i % 256;
      bit wr = (c == 0) && (i >= 256);
      bit hit_now = 0;
      if (wr && !wrap_en_i) stage = 2;
      else if (stage == 0 && c == h1) begin hit_now = 1; stage = 1; end
      else if (stage == 1 && c == h2) begin hit_now = 1; stage = 2; end
      cyc(c, 0, 0, '0, wr);
      exp_pin  = pulse ? hit_now : (exp_pin ^ hit_now);
      exp_flag = exp_flag | hit_now;
      chk({req, " pin"}, pin_o, exp_pin);
      chk("R3 flag", ctrl_o[7], exp_flag);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 cmp", cmp_o, 0);
    chk("R1 pin", pin_o, 0);
    chk("R1 irq", irq_o, 0);

    // toggle-mode sweep over compare values
    for (int v = 0; v < 256; v += 17) begin
      int park = (v + 128) % 256;
      wr_ctrl(32'h80, park);
      exp_pin = 0; exp_flag = 0;
      chk("R10 ctrl cleared", ctrl_o, 8'h00);
      chk("R10 pin low", pin_o, 0);
      wr_cmp({24'hFFFFFF, 8'(v)}, park);
      chk("R12 cmp low bits", cmp_o, v);
      cyc(v, 0, 0, '0, 0);
      chk("R7 no match in mode 0", ctrl_o[7], 0);
      wr_ctrl(32'h57, park);
      chk("R2 ctrl readback", ctrl_o, 8'h55);
      sweep(park + 1, park + 256, v, -1, 0, "R5");
      chk("R4 irq on flag", irq_o, 1);
      sweep(park + 1, park + 256, -1, -1, 0, "R9");
    end

    // write-1-to-clear and interrupt gating
    wr_ctrl(32'h55, 0);
    chk("R3 zero write keeps flag", ctrl_o, 8'hD5);
    wr_ctrl(32'h15, 0);
    chk("R4 irq off without ie", irq_o, 0);
    chk("R3 flag kept", ctrl_o, 8'h95);
    wr_ctrl(32'h95, 0);
    chk("R3 w1c", ctrl_o, 8'h15);
    wr_ctrl(32'h55, 0);
    chk("R4 irq off without flag", irq_o, 0);
    wr_cmp(40, 0);
    cyc(40, 1, 0, 32'hD5, 0);
    exp_pin = ~exp_pin;
    chk("R3 set wins over clear", ctrl_o, 8'hD5);
    chk("R5 pin on coincident", pin_o, exp_pin);

    // double buffer ordering
    wr_ctrl(32'h80, 0);
    exp_pin = 0; exp_flag = 0;
    wr_cmp(10, 0);
    wr_ctrl(32'h14, 0);
    wr_cmp(30, 0);
    wr_cmp(20, 1);
    chk("R8 active unchanged by queue", cmp_o, 10);
    sweep(2, 40, 10, 20, 0, "R8");
    chk("R8 promoted value", cmp_o, 20);
    wr_cmp(50, 41);
    cyc(50, 1, 1, 60, 0);
    exp_pin = ~exp_pin;
    chk("R8 coincident write arms", cmp_o, 60);
    chk("R8 pin on coincident", pin_o, exp_pin);
    sweep(51, 70, 60, -1, 0, "R8");

    // pulse mode
    wr_ctrl(32'h80, 0);
    exp_pin = 0; exp_flag = 0;
    wr_cmp(5, 0);
    wr_ctrl(32'h3C, 0);
    wr_cmp(7, 0);
    sweep(1, 15, 5, 7, 1, "R6");

    // disable drops both stages
    wr_ctrl(32'h80, 0);
    exp_pin = 0; exp_flag = 0;
    wr_cmp(3, 0);
    wr_ctrl(32'h14, 0);
    cyc(3, 0, 0, '0, 0);
    chk("R5 pin high", pin_o, 1);
    wr_cmp(8, 4);
    wr_cmp(9, 4);
    wr_ctrl(32'h00, 4);
    chk("R10 pin cleared", pin_o, 0);
    chk("R10 flag survives zero write", ctrl_o, 8'h80);
    wr_ctrl(32'h94, 4);
    exp_pin = 0; exp_flag = 0;
    sweep(5, 20, -1, -1, 0, "R10");

    // counter wrap
    wr_ctrl(32'h80, 50);
    wrap_en_i = 1'b0;
    exp_pin = 0; exp_flag = 0;
    wr_cmp(10, 50);
    wr_ctrl(32'h14, 50);
    sweep(51, 276, 10, -1, 0, "R11 blocked");
    wr_ctrl(32'h80, 50);
    wrap_en_i = 1'b1;
    exp_pin = 0; exp_flag = 0;
    wr_cmp(10, 50);
    wr_ctrl(32'h14, 50);
    sweep(51, 276, 10, -1, 0, "R11 permitted");
    chk("R11 match after wrap", ctrl_o[7], 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule